// File: doc/BRIEF.md
# Multiplierless 8-Point Forward DCT Engine

This block takes eight signed samples in parallel and returns their eight orthonormal one-dimensional DCT-II coefficients. It has no hardware multipliers. Every constant product by a cosine is built from a network of shifted adds over a fixed 13-bit coefficient. The datapath follows a Chen-style fast factorization. An input butterfly splits the vector into sums and differences. A pi/4 rotation combines the middle differences. Four 2x2 constant rotations then produce the coefficient pairs (0,4), (2,6), (1,7) and (5,3).

The engine is fully pipelined. It accepts a new vector on any clock edge where the input strobe is high. Each result appears with its own strobe a fixed three edges later. The factorization produces the outputs in a scrambled order, and the block puts them back into natural frequency order before they leave. Intermediate values keep all of their fractional bits, and rounding happens once at the output. It is meant for the row or column pass of a block transform in an image or video coder.

Top module: `dct8_shiftadd`

## Requirements
- R1: Sample n (n = 0..7) is the 9-bit two's-complement value at `in_samples[9n+8:9n]`. Coefficient k (k = 0..7) is the 12-bit two's-complement value at `out_coefs[12k+11:12k]`, in natural frequency order.
- R2: Each coefficient is within 1 LSB of X_k = (c_k/2) * sum over n of x_n*cos((2n+1)k*pi/16), with c_0 = 1/sqrt(2) and c_k = 1 otherwise.
- R3: Inputs anywhere in the full range -256..255 produce correct coefficients with no wrap-around. This includes all-maximum, all-minimum and alternating-extreme vectors.
- R4: A vector sampled on an edge with `in_valid` high produces `out_valid` high exactly three rising edges later, together with its coefficients.
- R5: Vectors may arrive on consecutive edges. Each one yields its own result on consecutive cycles, in arrival order.
- R6: `out_valid` is high only in cycles that carry the result of an accepted vector.
- R7: While `out_valid` is low, `out_coefs` holds the last result. Samples presented with `in_valid` low have no effect on the outputs.
- R8: Synchronous active-high `rst` clears every valid bit and zeroes `out_coefs`. Vectors in flight when reset is asserted never produce an output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input vector strobe |
| in_samples | input | 72 | Eight signed 9-bit samples, sample n at bits 9n+8:9n |
| out_valid | output | 1 | Result strobe |
| out_coefs | output | 96 | Eight signed 12-bit coefficients, coefficient k at bits 12k+11:12k |

## Verification
The hardest cases to reach from the ports are the coefficients near the rounding limits, where constant quantization and output rounding together could exceed one LSB. Random vectors rarely go there. Directed vectors with all samples at one extreme, or alternating between the extremes, push X0 and X7 to their largest magnitudes, and single-sample impulses place the energy in every rotation one position at a time. A reset asserted while a vector is still inside the pipeline is forced on purpose, and the bench then watches the outputs for any stray result.

// File: rtl/dct8_pkg.sv
package dct8_pkg;
    // Fixed-point format of the cosine constants: value = K / 2**FRAC
    localparam int COEF_W = 13;
    localparam int FRAC   = COEF_W - 1;

    // round(cos(m*pi/16) * 2**FRAC) for m = 1..7
    localparam int K_C1 = 4017;
    localparam int K_C2 = 3784;
    localparam int K_C3 = 3406;
    localparam int K_C4 = 2896;
    localparam int K_C5 = 2276;
    localparam int K_C6 = 1567;
    localparam int K_C7 = 799;
endpackage

// File: rtl/dct8_rot.sv
// 2x2 constant rotation built from shifted adds:
//   y0 = p*KA + q*KB
//   y1 = p*KB - q*KA
module dct8_rot
    import dct8_pkg::*;
#(
    parameter int IN_W  = 10,
    parameter int KA    = K_C4,
    parameter int KB    = K_C4,
    parameter int OUT_W = IN_W + COEF_W + 1
) (
    input  logic signed [IN_W-1:0]  p,
    input  logic signed [IN_W-1:0]  q,
    output logic signed [OUT_W-1:0] y0,
    output logic signed [OUT_W-1:0] y1
);
    function automatic logic signed [OUT_W-1:0] shadd(
        input logic signed [OUT_W-1:0] x,
        input int                      k
    );
        logic signed [OUT_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < COEF_W; i++) begin
            if (k[i]) acc = acc + (x <<< i);
        end
        return acc;
    endfunction

    logic signed [OUT_W-1:0] p_ext, q_ext;
    logic signed [OUT_W-1:0] p_a, p_b, q_a, q_b;

    always_comb begin
        p_ext = OUT_W'(p);
        q_ext = OUT_W'(q);
        p_a   = shadd(p_ext, KA);
        p_b   = shadd(p_ext, KB);
        q_a   = shadd(q_ext, KA);
        q_b   = shadd(q_ext, KB);
        y0    = p_a + q_b;
        y1    = p_b - q_a;
    end
endmodule

// File: rtl/dct8_round.sv
// Round-half-up shift to the output width, with a range flag.
module dct8_round #(
    parameter int IN_W  = 25,
    parameter int SHIFT = 13,
    parameter int OUT_W = 12
) (
    input  logic signed [IN_W-1:0]  x,
    output logic signed [OUT_W-1:0] y,
    output logic                    fits
);
    localparam logic signed [IN_W-1:0] BIAS =
        {{(IN_W-SHIFT){1'b0}}, 1'b1, {(SHIFT-1){1'b0}}};

    logic signed [IN_W-1:0]    full;
    logic [IN_W-OUT_W:0]       top;

    always_comb begin
        full = (x + BIAS) >>> SHIFT;
        y    = full[OUT_W-1:0];
        top  = full[IN_W-1:OUT_W-1];
        fits = (&top) | ~(|top);
    end
endmodule

// File: rtl/dct8_shiftadd.sv
module dct8_shiftadd
    import dct8_pkg::*;
#(
    parameter int DIN_W  = 9,
    parameter int DOUT_W = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [8*DIN_W-1:0]    in_samples,
    output logic                  out_valid,
    output logic [8*DOUT_W-1:0]   out_coefs
);
    localparam int W1   = DIN_W + 1;          // after input butterfly
    localparam int W2   = DIN_W + 2;          // even sums/differences
    localparam int RW_C = W1 + COEF_W + 1;    // pi/4 rotation, Q(FRAC)
    localparam int HW   = RW_C + 1;           // odd combination, Q(FRAC)
    localparam int RW_E = W2 + COEF_W + 1;    // even rotations, Q(FRAC)
    localparam int RW_O = HW + COEF_W + 1;    // odd rotations, Q(2*FRAC)

    typedef struct packed {
        logic                     v1;
        logic [3:0][W1-1:0]       sa;
        logic [3:0][W1-1:0]       sd;
        logic                     v2;
        logic [3:0][W2-1:0]       ev;
        logic [W1-1:0]            od0;
        logic [W1-1:0]            od3;
        logic [RW_C-1:0]          rv;
        logic [RW_C-1:0]          rw;
        logic                     v3;
        logic [7:0][DOUT_W-1:0]   co;
    } pipe_t;

    pipe_t st_d, st_q;

    // Signed views of inputs and registered stage values
    logic signed [DIN_W-1:0] xs   [8];
    logic signed [W1-1:0]    sa_s [4];
    logic signed [W1-1:0]    sd_s [4];
    logic signed [W2-1:0]    ev_s [4];

    for (genvar n = 0; n < 8; n++) begin : g_in
        assign xs[n] = in_samples[n*DIN_W +: DIN_W];
    end
    for (genvar i = 0; i < 4; i++) begin : g_view
        assign sa_s[i] = st_q.sa[i];
        assign sd_s[i] = st_q.sd[i];
        assign ev_s[i] = st_q.ev[i];
    end

    // Stage 2 odd path: pi/4 rotation of the middle differences
    logic signed [RW_C-1:0] rot_v, rot_w;
    dct8_rot #(.IN_W(W1), .KA(K_C4), .KB(K_C4), .OUT_W(RW_C)) u_rot_mid (
        .p(sd_s[1]), .q(sd_s[2]), .y0(rot_v), .y1(rot_w)
    );

    // Stage 3 odd path: combine outer differences with rotated middle
    logic signed [HW-1:0] h0, h1, h2, h3;
    always_comb begin
        h0 = (HW'($signed(st_q.od0)) <<< FRAC) + HW'($signed(st_q.rv));
        h1 = (HW'($signed(st_q.od0)) <<< FRAC) - HW'($signed(st_q.rv));
        h2 = (HW'($signed(st_q.od3)) <<< FRAC) - HW'($signed(st_q.rw));
        h3 = (HW'($signed(st_q.od3)) <<< FRAC) + HW'($signed(st_q.rw));
    end

    // Stage 3 rotations; ye = {X0,X4,X2,X6}, yo = {X1,X7,X5,X3} (scaled)
    logic signed [RW_E-1:0] ye [4];
    logic signed [RW_O-1:0] yo [4];

    dct8_rot #(.IN_W(W2), .KA(K_C4), .KB(K_C4), .OUT_W(RW_E)) u_rot_dc (
        .p(ev_s[0]), .q(ev_s[1]), .y0(ye[0]), .y1(ye[1])
    );
    dct8_rot #(.IN_W(W2), .KA(K_C2), .KB(K_C6), .OUT_W(RW_E)) u_rot_26 (
        .p(ev_s[3]), .q(ev_s[2]), .y0(ye[2]), .y1(ye[3])
    );
    dct8_rot #(.IN_W(HW), .KA(K_C1), .KB(K_C7), .OUT_W(RW_O)) u_rot_17 (
        .p(h0), .q(h3), .y0(yo[0]), .y1(yo[1])
    );
    dct8_rot #(.IN_W(HW), .KA(K_C5), .KB(K_C3), .OUT_W(RW_O)) u_rot_53 (
        .p(h1), .q(h2), .y0(yo[2]), .y1(yo[3])
    );

    logic signed [DOUT_W-1:0] re [4];
    logic signed [DOUT_W-1:0] ro [4];
    logic [3:0] fit_e, fit_o;

    for (genvar j = 0; j < 4; j++) begin : g_rnd
        dct8_round #(.IN_W(RW_E), .SHIFT(FRAC+1), .OUT_W(DOUT_W)) u_re (
            .x(ye[j]), .y(re[j]), .fits(fit_e[j])
        );
        dct8_round #(.IN_W(RW_O), .SHIFT(2*FRAC+1), .OUT_W(DOUT_W)) u_ro (
            .x(yo[j]), .y(ro[j]), .fits(fit_o[j])
        );
    end

    // Next-state computation
    always_comb begin
        st_d = st_q;

        // Stage 1: input butterfly, loaded only on an accepted vector
        st_d.v1 = in_valid;
        if (in_valid) begin
            for (int i = 0; i < 4; i++) begin
                st_d.sa[i] = W1'(xs[i]) + W1'(xs[7-i]);
                st_d.sd[i] = W1'(xs[i]) - W1'(xs[7-i]);
            end
        end

        // Stage 2: even butterfly and middle rotation
        st_d.v2 = st_q.v1;
        if (st_q.v1) begin
            st_d.ev[0] = W2'(sa_s[0]) + W2'(sa_s[3]);
            st_d.ev[1] = W2'(sa_s[1]) + W2'(sa_s[2]);
            st_d.ev[2] = W2'(sa_s[1]) - W2'(sa_s[2]);
            st_d.ev[3] = W2'(sa_s[0]) - W2'(sa_s[3]);
            st_d.od0   = st_q.sd[0];
            st_d.od3   = st_q.sd[3];
            st_d.rv    = rot_v;
            st_d.rw    = rot_w;
        end

        // Stage 3: output rotations, rounding, natural-order placement
        st_d.v3 = st_q.v2;
        if (st_q.v2) begin
            st_d.co[0] = re[0];
            st_d.co[4] = re[1];
            st_d.co[2] = re[2];
            st_d.co[6] = re[3];
            st_d.co[1] = ro[0];
            st_d.co[7] = ro[1];
            st_d.co[5] = ro[2];
            st_d.co[3] = ro[3];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.v3;
    assign out_coefs = st_q.co;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && !st_q.v1 && !st_q.v2 && out_coefs == '0)); // R8
    AST_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> st_q.v1); // R4
    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        st_q.v2 |=> out_valid); // R4
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !st_q.v2 |=> !out_valid); // R6
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !st_q.v2 |=> $stable(out_coefs)); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        st_q.v2 |-> (&fit_e && &fit_o)); // R3
endmodule

// File: tb/dct8_shiftadd_test.sv
module dct8_shiftadd_test;
    localparam int DIN_W  = 9;
    localparam int DOUT_W = 12;
    localparam int LAT    = 3;
    localparam real PI    = 3.14159265358979323846;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  in_valid = 1'b0;
    logic [8*DIN_W-1:0]    in_samples = '0;
    logic                  out_valid;
    logic [8*DOUT_W-1:0]   out_coefs;

    dct8_shiftadd #(.DIN_W(DIN_W), .DOUT_W(DOUT_W)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_samples(in_samples),
        .out_valid(out_valid), .out_coefs(out_coefs)
    );

    always #10 clk = ~clk;   // 50 MHz

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int errors = 0;

    logic [8*DIN_W-1:0]  q_vec [$];
    int                  q_t   [$];
    string               q_tag [$];
    logic [8*DOUT_W-1:0] last_out;
    bit                  have_last = 0;

    function automatic real ref_coef(logic [8*DIN_W-1:0] v, int k);
        real acc = 0.0;
        for (int n = 0; n < 8; n++) begin
            int xi;
            xi = $signed(v[n*DIN_W +: DIN_W]);
            acc += xi * $cos((2*n+1) * k * PI / 16.0);
        end
        return (k == 0) ? acc / (2.0 * $sqrt(2.0)) : acc / 2.0;
    endfunction

    task automatic check(bit ok, string req, string what, real act, real exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0f expected %0f", req, what, act, exp);
        end
    endtask

    // Output monitor, sampling on the falling edge
    always @(negedge clk) begin
        if (rst) begin
            have_last = 0;
        end else if (out_valid) begin
            if (q_vec.size() == 0) begin
                check(0, "R6", "out_valid with no pending vector", 1.0, 0.0);
            end else begin
                logic [8*DIN_W-1:0] v;
                int t;
                string tag;
                v = q_vec.pop_front();
                t = q_t.pop_front();
                tag = q_tag.pop_front();
                check(cyc - t == LAT, "R4", "latency", real'(cyc - t), real'(LAT));
                for (int k = 0; k < 8; k++) begin
                    int a;
                    real e, d;
                    a = $signed(out_coefs[k*DOUT_W +: DOUT_W]);
                    e = ref_coef(v, k);
                    d = a - e;
                    check(d <= 1.0 && d >= -1.0, tag, $sformatf("coef %0d", k), real'(a), e);
                end
                last_out = out_coefs;
                have_last = 1;
            end
        end else if (have_last) begin
            check(out_coefs == last_out, "R7", "hold while idle",
                  real'($signed(out_coefs[DOUT_W-1:0])), real'($signed(last_out[DOUT_W-1:0])));
        end
    end

    task automatic send(logic [8*DIN_W-1:0] v, string tag);
        @(negedge clk);
        in_valid   = 1'b1;
        in_samples = v;
        q_vec.push_back(v);
        q_t.push_back(cyc);
        q_tag.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid   = 1'b0;
            in_samples = {$urandom, $urandom, $urandom};   // ignored data, R7
        end
    endtask

    function automatic logic [8*DIN_W-1:0] fill(int a, int b);
        logic [8*DIN_W-1:0] v;
        for (int n = 0; n < 8; n++) v[n*DIN_W +: DIN_W] = DIN_W'((n % 2 == 0) ? a : b);
        return v;
    endfunction

    function automatic logic [8*DIN_W-1:0] rand_vec();
        logic [8*DIN_W-1:0] v;
        for (int n = 0; n < 8; n++) v[n*DIN_W +: DIN_W] = DIN_W'($urandom_range(0, 511));
        return v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "R4", "watchdog expired", 0.0, 1.0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5eed_0d37);

        // Reset state, R8
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R8", "out_valid in reset", real'(out_valid), 0.0);
        check(out_coefs == '0, "R8", "coefs in reset", real'(out_coefs != '0), 0.0);
        rst = 1'b0;
        idle(2);
        check(out_valid == 1'b0, "R6", "idle after reset", real'(out_valid), 0.0);

        // Directed vectors
        send('0, "R2");
        send(fill(255, 255), "R3");
        send(fill(-256, -256), "R3");
        send(fill(255, -256), "R3");
        send(fill(-256, 255), "R3");
        idle(1);
        for (int p = 0; p < 8; p++) begin   // impulses: R1 field positions and order
            logic [8*DIN_W-1:0] v;
            v = '0;
            v[p*DIN_W +: DIN_W] = DIN_W'(200 - 37 * p);
            send(v, "R1");
        end
        begin
            logic [8*DIN_W-1:0] v;
            for (int n = 0; n < 8; n++) v[n*DIN_W +: DIN_W] = DIN_W'(-200 + 57 * n);
            send(v, "R2");
        end
        idle(5);

        // Reset with a vector in flight, R8
        @(negedge clk);
        in_valid   = 1'b1;
        in_samples = fill(100, -50);
        @(negedge clk);
        in_valid = 1'b0;
        rst      = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R8", "flushed vector", real'(out_valid), 0.0);
        end
        check(out_coefs == '0, "R8", "coefs after flush", real'(out_coefs != '0), 0.0);

        // Back-to-back stream, R5
        for (int i = 0; i < 40; i++) send(rand_vec(), "R5");
        idle(4);

        // Random with gaps
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(0, 9) < 7) send(rand_vec(), "R2");
            else idle($urandom_range(1, 3));
        end
        idle(8);
        check(q_vec.size() == 0, "R6", "all results delivered", real'(q_vec.size()), 0.0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule